// File: doc/BRIEF.md
# Keyed Watchdog Timer with Register Lock

This block is a watchdog peripheral reached over a byte-wide write port made of an address, a data byte and a write strobe. A 16-bit period is written in two bytes. The write of the low byte loads the full period and starts a countdown. The countdown runs on a slow strobe of about 1.024 kHz, so a period of P milliseconds is programmed as P*1024/1000 counts. Software keeps the system alive by writing one specific key byte, which restarts the countdown from the stored period. If the countdown runs out, the block raises a one-cycle reset request and stops.

A configuration byte has two jobs. It enables key matching and picks the tick source. Its low nibble also acts as a write lock for the setup registers. The key register and the pre-warning registers stay writable while locked, so the normal servicing sequence still works after setup. A control bit chooses whether a running watchdog may be halted. A separate pre-warning countdown raises a sticky interrupt ahead of the reset. It reloads itself after each expiry, so it can fire again and again during the critical window.

Register offsets (addr_i): 0 configuration, 1 control, 2 period high byte, 3 period low byte, 4 key, 5 companion-timer start, 6 pre-warning interval, 7 pre-warning control.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, run_o, rst_req_o and warn_irq_o are all low, the registers are unlocked and the companion timer is stopped.
- R2: A write to offset 3 loads the period {high byte, written byte} and sets run_o in the next cycle. A write to offset 2 alone does not start counting.
- R3: While running, each counted tick lowers the count by one. The tick that takes the count to zero (or that arrives with the count already zero) clears run_o and pulses rst_req_o in the next cycle.
- R4: When configuration bit 5 is set, a write of 0x5C to offset 4 restarts the count from the stored period. This restart also re-arms a watchdog that has expired, once a period has been loaded. Any other key value, and any key write while bit 5 is clear, has no effect.
- R5: With configuration bit 4 set, ticks are counted only after any write to offset 5 has started the companion timer. With bit 4 clear, every tick is counted.
- R6: The registers are locked while configuration bits 3:0 are all ones (for example after writing 0x3F). While locked, writes to offsets 1, 2, 3 and 5 are ignored, and configuration writes other than 0x00 are ignored. Writing 0x00 unlocks. The key and pre-warning registers stay writable.
- R7: Control bit 4 allows stopping. Writing control with bits 4 and 0 set halts counting, and writing 0x10 resumes it. While running with bit 4 clear, control writes are ignored, so the watchdog cannot be halted.
- R8: Offset 6 holds the pre-warning interval N in ticks. At offset 7, bit 0 enables the pre-warning counter and bit 1 restarts it from N, so 0x03 enables and restarts. On the N-th raw tick it sets warn_irq_o and reloads N, which makes it fire every N ticks.
- R9: warn_irq_o is sticky and is cleared by any write to offset 7. If an expiry occurs in the same cycle as such a write, the interrupt stays set.
- R10: rst_req_o is high for exactly one cycle per expiry. After expiry the watchdog stays stopped and issues no further request until it is reloaded through offset 3 or restarted by the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe at the slow tick rate (about 1.024 kHz) |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data byte |
| rst_req_o | output | 1 | One-cycle system reset request on expiry |
| warn_irq_o | output | 1 | Sticky pre-warning interrupt |
| run_o | output | 1 | High while the watchdog countdown is armed and running |

## Verification
Most internal faults show up at the ports as a wrong moment for rst_req_o. A count that restarts on a wrong key, a lost lock, or a halt accepted when stopping is forbidden all move the reset request by at least one tick, or make it disappear. The bench therefore counts ticks exactly and checks run_o and rst_req_o after every tick around each expected expiry. A broken pre-warning reload or clear shows in warn_irq_o within N ticks. A bad tick-source gate shows the first time a tick is counted when it should not be, or skipped when it should be counted.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_CFG     = 3'd0,
    OFS_CTRL    = 3'd1,
    OFS_PER_HI  = 3'd2,
    OFS_PER_LO  = 3'd3,
    OFS_KEY     = 3'd4,
    OFS_T1_GO   = 3'd5,
    OFS_PW_IVAL = 3'd6,
    OFS_PW_CTRL = 3'd7
  } wd_ofs_e;

  localparam logic [BYTE_W-1:0] CFG_UNLOCK = 8'h00;

  // configuration bit positions
  localparam int CFG_KEY_EN_BIT = 5;
  localparam int CFG_TSEL_BIT   = 4;
  localparam int CFG_LOCK_HI    = 3;

  // control bit positions
  localparam int CTRL_STOP_OK_BIT = 4;
  localparam int CTRL_HALT_BIT    = 0;

  // pre-warning control bit positions
  localparam int PWC_EN_BIT  = 0;
  localparam int PWC_RST_BIT = 1;

endpackage

// File: rtl/kw_regs.sv
module kw_regs
  import keyed_wdog_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PW_W  = 8,
  parameter logic [BYTE_W-1:0] KEY_VAL = 8'h5C
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [OFS_W-1:0]      addr,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic                  wd_running,
  output logic                  locked,
  output logic                  tick_sel,
  output logic                  stop_ok,
  output logic                  halt,
  output logic                  t1_run,
  output logic [CNT_W-1:0]      period,
  output logic [CNT_W-1:0]      load_val,
  output logic                  load_p,
  output logic                  kick_p,
  output logic [PW_W-1:0]       pw_ival,
  output logic                  pw_en,
  output logic                  pw_restart_p,
  output logic                  pw_clr_p
);

  localparam int HI_W  = CNT_W - BYTE_W;
  localparam int CFG_W = CFG_KEY_EN_BIT + 1;

  logic [CFG_W-1:0]  cfg_q;
  logic              stop_ok_q, halt_q, t1_q, pw_en_q;
  logic [HI_W-1:0]   hi_q;
  logic [BYTE_W-1:0] lo_q;
  logic [PW_W-1:0]   pw_ival_q;

  logic wr_cfg, wr_ctrl, wr_hi, wr_lo, wr_key, wr_t1, wr_pwi, wr_pwc;
  logic open_q, ctrl_frozen;

  always_comb begin
    wr_cfg  = wr_en && (addr == OFS_CFG);
    wr_ctrl = wr_en && (addr == OFS_CTRL);
    wr_hi   = wr_en && (addr == OFS_PER_HI);
    wr_lo   = wr_en && (addr == OFS_PER_LO);
    wr_key  = wr_en && (addr == OFS_KEY);
    wr_t1   = wr_en && (addr == OFS_T1_GO);
    wr_pwi  = wr_en && (addr == OFS_PW_IVAL);
    wr_pwc  = wr_en && (addr == OFS_PW_CTRL);
    open_q      = !(&cfg_q[CFG_LOCK_HI:0]);
    ctrl_frozen = wd_running && !stop_ok_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      stop_ok_q <= 1'b0;
      halt_q    <= 1'b0;
      t1_q      <= 1'b0;
      hi_q      <= '0;
      lo_q      <= '0;
      pw_ival_q <= '0;
      pw_en_q   <= 1'b0;
    end else begin
      if (wr_cfg && (open_q || wdata == CFG_UNLOCK))
        cfg_q <= wdata[CFG_W-1:0];
      if (wr_ctrl && open_q && !ctrl_frozen) begin
        stop_ok_q <= wdata[CTRL_STOP_OK_BIT];
        halt_q    <= wdata[CTRL_STOP_OK_BIT] & wdata[CTRL_HALT_BIT];
      end
      if (wr_hi && open_q) hi_q <= wdata[HI_W-1:0];
      if (wr_lo && open_q) lo_q <= wdata;
      if (wr_t1 && open_q) t1_q <= 1'b1;
      if (wr_pwi) pw_ival_q <= wdata[PW_W-1:0];
      if (wr_pwc) pw_en_q <= wdata[PWC_EN_BIT];
    end
  end

  always_comb begin
    locked       = !open_q;
    tick_sel     = cfg_q[CFG_TSEL_BIT];
    stop_ok      = stop_ok_q;
    halt         = halt_q;
    t1_run       = t1_q;
    period       = {hi_q, lo_q};
    load_val     = {hi_q, wdata};
    load_p       = wr_lo && open_q;
    kick_p       = wr_key && cfg_q[CFG_KEY_EN_BIT] && (wdata == KEY_VAL);
    pw_ival      = pw_ival_q;
    pw_en        = pw_en_q;
    pw_restart_p = wr_pwc && wdata[PWC_RST_BIT];
    pw_clr_p     = wr_pwc;
  end

endmodule

// File: rtl/kw_wdcount.sv
module kw_wdcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_p,
  input  logic [CNT_W-1:0] load_val,
  input  logic             kick_p,
  input  logic [CNT_W-1:0] period,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, armed_q, exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      exp_q   <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (load_p) begin
        cnt_q   <= load_val;
        run_q   <= 1'b1;
        armed_q <= 1'b1;
      end else if (kick_p && armed_q) begin
        cnt_q <= period;
        run_q <= 1'b1;
      end else if (run_q && step) begin
        if (cnt_q <= ONE) begin
          cnt_q <= '0;
          run_q <= 1'b0;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
  assign expire  = exp_q;

endmodule

// File: rtl/kw_prewarn.sv
module kw_prewarn #(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            en,
  input  logic            restart_p,
  input  logic            clr_p,
  input  logic [PW_W-1:0] ival,
  output logic            irq
);

  localparam logic [PW_W-1:0] ONE = PW_W'(1);

  logic [PW_W-1:0] cnt_q;
  logic            irq_q;
  logic            fire;

  always_comb fire = !restart_p && en && tick && (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (restart_p)
        cnt_q <= ival;
      else if (en && tick)
        cnt_q <= (cnt_q <= ONE) ? ival : cnt_q - ONE;

      if (fire)
        irq_q <= 1'b1;
      else if (clr_p)
        irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PW_W  = 8,
  parameter logic [BYTE_W-1:0] KEY_VAL = 8'h5C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              rst_req_o,
  output logic              warn_irq_o,
  output logic              run_o
);

  logic             locked, tick_sel, stop_ok, halt, t1_run;
  logic [CNT_W-1:0] period, load_val, count;
  logic             load_p, kick_p;
  logic [PW_W-1:0]  pw_ival;
  logic             pw_en, pw_restart_p, pw_clr_p;
  logic             running, expire, irq;
  logic             wd_tick, step;

  kw_regs #(.CNT_W(CNT_W), .PW_W(PW_W), .KEY_VAL(KEY_VAL)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
    .wd_running(running), .locked(locked), .tick_sel(tick_sel),
    .stop_ok(stop_ok), .halt(halt), .t1_run(t1_run), .period(period),
    .load_val(load_val), .load_p(load_p), .kick_p(kick_p),
    .pw_ival(pw_ival), .pw_en(pw_en), .pw_restart_p(pw_restart_p),
    .pw_clr_p(pw_clr_p)
  );

  always_comb begin
    wd_tick = tick_sel ? (tick_i && t1_run) : tick_i;
    step    = wd_tick && !halt;
  end

  kw_wdcount #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .load_p(load_p), .load_val(load_val),
    .kick_p(kick_p), .period(period), .step(step), .count(count),
    .running(running), .expire(expire)
  );

  kw_prewarn #(.PW_W(PW_W)) pw_i (
    .clk(clk), .rst(rst), .tick(tick_i), .en(pw_en),
    .restart_p(pw_restart_p), .clr_p(pw_clr_p), .ival(pw_ival), .irq(irq)
  );

  assign rst_req_o  = expire;
  assign warn_irq_o = irq;
  assign run_o      = running;

endmodule

// File: rtl/kw_checker.sv
module kw_checker
  import keyed_wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rst_req,
  input logic             run,
  input logic             locked,
  input logic             wr_en,
  input logic [OFS_W-1:0] addr,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] count,
  input logic             kick,
  input logic             load,
  input logic             stop_ok,
  input logic             irq,
  input logic             pw_clr
);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  assert_stop_on_expire_R3: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !run);

  assert_count_falls_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !load && !kick) |=> (count <= $past(count)));

  assert_locked_period_R6: assert property (@(posedge clk) disable iff (rst)
    (locked && wr_en && (addr == OFS_PER_HI || addr == OFS_PER_LO)) |=> $stable(period));

  assert_kick_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (kick && !load) |=> (!run || count == $past(period)));

  assert_no_unstop_R7: assert property (@(posedge clk) disable iff (rst)
    (run && !stop_ok) |=> !stop_ok);

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq && !pw_clr) |=> irq);

endmodule

bind keyed_wdog kw_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .rst_req(rst_req_o), .run(run_o), .locked(locked),
  .wr_en(wr_en_i), .addr(addr_i), .period(period), .count(count),
  .kick(kick_p), .load(load_p), .stop_ok(stop_ok), .irq(warn_irq_o),
  .pw_clr(pw_clr_p)
);

// File: tb/keyed_wdog_tb_top.sv
module keyed_wdog_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'd0;
  logic       rst_req_o, warn_irq_o, run_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic rs;

  always #4 clk = ~clk;

  keyed_wdog dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rst_req_o(rst_req_o),
    .warn_irq_o(warn_irq_o), .run_o(run_o)
  );

  // vector: {tick_op, offset, data, exp_run, exp_rst_req, exp_irq}
  localparam logic [14:0] VEC [0:23] = '{
    {1'b0, 3'd0, 8'h30, 3'b000},
    {1'b0, 3'd5, 8'h00, 3'b000},
    {1'b0, 3'd2, 8'h00, 3'b000},
    {1'b0, 3'd3, 8'h03, 3'b100},
    {1'b1, 3'd0, 8'h00, 3'b100},
    {1'b1, 3'd0, 8'h00, 3'b100},
    {1'b0, 3'd4, 8'h5A, 3'b100},
    {1'b1, 3'd0, 8'h00, 3'b010},
    {1'b1, 3'd0, 8'h00, 3'b000},
    {1'b0, 3'd4, 8'h5C, 3'b100},
    {1'b1, 3'd0, 8'h00, 3'b100},
    {1'b0, 3'd4, 8'h5C, 3'b100},
    {1'b1, 3'd0, 8'h00, 3'b100},
    {1'b1, 3'd0, 8'h00, 3'b100},
    {1'b1, 3'd0, 8'h00, 3'b010},
    {1'b0, 3'd6, 8'h02, 3'b000},
    {1'b0, 3'd7, 8'h03, 3'b000},
    {1'b1, 3'd0, 8'h00, 3'b000},
    {1'b1, 3'd0, 8'h00, 3'b001},
    {1'b0, 3'd7, 8'h01, 3'b000},
    {1'b1, 3'd0, 8'h00, 3'b000},
    {1'b1, 3'd0, 8'h00, 3'b001},
    {1'b0, 3'd7, 8'h00, 3'b000},
    {1'b1, 3'd0, 8'h00, 3'b000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d,
                      input logic t, output logic r);
    @(negedge clk);
    wr_en_i = w; addr_i = a; wdata_i = d; tick_i = t;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    r = rst_req_o;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, rs);
  endtask

  task automatic tk();
    step(1'b0, 3'd0, 8'h00, 1'b1, rs);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog timeout actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 run", run_o, 0);
    chk("R1 rst_req", rst_req_o, 0);
    chk("R1 irq", warn_irq_o, 0);

    // table walk: R2 R3 R4 R8 R9 R10
    for (int i = 0; i < 24; i++) begin
      step(!VEC[i][14], VEC[i][13:11], VEC[i][10:3], VEC[i][14], rs);
      chk($sformatf("R3/R4/R8/R10 vec%0d run", i), run_o, VEC[i][2]);
      chk($sformatf("R3/R10 vec%0d rst_req", i), rs, VEC[i][1]);
      chk($sformatf("R8/R9 vec%0d irq", i), warn_irq_o, VEC[i][0]);
    end

    // R1: reset clears a running watchdog
    wr(3'd3, 8'h05);
    do_reset();
    chk("R1 run after reset", run_o, 0);

    // R2: high byte alone does not start; full 16-bit period of 256
    wr(3'd2, 8'h01);
    tk();
    chk("R2 high byte no start", run_o, 0);
    wr(3'd3, 8'h00);
    chk("R2 low byte starts", run_o, 1);
    for (int i = 0; i < 255; i++) begin
      tk();
      if (rs) chk("R2 early expiry", rs, 0);
    end
    chk("R2 running at 255", run_o, 1);
    tk();
    chk("R2 expiry at 256", rs, 1);
    chk("R3 stopped after expiry", run_o, 0);

    // R5: tick source gate
    do_reset();
    wr(3'd0, 8'h30);
    wr(3'd3, 8'h02);
    tk(); tk(); tk();
    chk("R5 no count before timer start", run_o, 1);
    wr(3'd5, 8'h00);
    tk();
    chk("R5 counts after start", rs, 0);
    tk();
    chk("R5 expiry after 2 ticks", rs, 1);
    do_reset();
    wr(3'd0, 8'h20);
    wr(3'd3, 8'h01);
    tk();
    chk("R5 raw tick counted", rs, 1);

    // R4: key ignored when key matching is off
    do_reset();
    wr(3'd0, 8'h10);
    wr(3'd5, 8'h00);
    wr(3'd3, 8'h02);
    tk();
    wr(3'd4, 8'h5C);
    tk();
    chk("R4 key ignored when disabled", rs, 1);

    // R6: lock behaviour
    do_reset();
    wr(3'd0, 8'h30);
    wr(3'd5, 8'h00);
    wr(3'd3, 8'h05);
    wr(3'd0, 8'h3F);
    wr(3'd3, 8'h01);
    tk();
    chk("R6 locked period write ignored", run_o, 1);
    wr(3'd0, 8'h30);
    wr(3'd4, 8'h5C);
    for (int i = 0; i < 4; i++) tk();
    chk("R6 key works while locked", run_o, 1);
    tk();
    chk("R6 expiry after kick", rs, 1);
    wr(3'd3, 8'h02);
    chk("R6 still locked", run_o, 0);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h30);
    wr(3'd3, 8'h02);
    chk("R6 unlocked load starts", run_o, 1);

    // R7: stoppable watchdog halts and resumes
    do_reset();
    wr(3'd0, 8'h30);
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h10);
    wr(3'd3, 8'h02);
    wr(3'd1, 8'h11);
    tk(); tk(); tk();
    chk("R7 halted no expiry", run_o, 1);
    wr(3'd1, 8'h10);
    tk();
    chk("R7 resumed tick one", rs, 0);
    tk();
    chk("R7 resumed expiry", rs, 1);
    // R7: non-stoppable ignores halt
    do_reset();
    wr(3'd0, 8'h30);
    wr(3'd5, 8'h00);
    wr(3'd3, 8'h02);
    wr(3'd1, 8'h11);
    tk();
    tk();
    chk("R7 halt refused", rs, 1);

    // R9: expiry wins over clear in the same cycle
    do_reset();
    wr(3'd6, 8'h01);
    wr(3'd7, 8'h03);
    step(1'b1, 3'd7, 8'h01, 1'b1, rs);
    chk("R9 set wins over clear", warn_irq_o, 1);
    wr(3'd7, 8'h01);
    chk("R9 clear by write", warn_irq_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule